// File: doc/BRIEF.md
# BCD clock-calendar counter

This block keeps the time of day and the calendar date as seven packed-BCD bytes. It advances by one second on every cycle where the one-second enable `tick_1hz` is high. The bytes are seconds, minutes, hours, date, month, day of week and a two-digit year. Each carry passes on to the next field in the same cycle, so one tick can move every field at once, for example 23:59:59 on 31 December of year 99 to 00:00:00 on 1 January of year 00. The date wrap allows for month length and for leap years.

The hours byte works in one of two modes. In 24-hour mode bit 5 is the tens bit for hours 20 to 23. In 12-hour mode the same bit is the afternoon flag. Bit 7 of the seconds byte stops the count while it is set. A small register-file port lets a neighbouring block write any byte by its 3-bit address and read it back one cycle later. Address 7 is empty.

Top module: `bcd_calendar`

## Requirements
- R1: After a synchronous reset the bytes read seconds 00, minutes 00, hours 00 (24-hour mode, midnight), date 01, month 01, day of week 01, year 00.
- R2: Address map: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year. A write with `wr_en` high stores `wr_data` at `addr` on that clock edge. `rd_data` shows the byte at `addr`, sampled on a clock edge and valid after that edge. Address 7 stores nothing and reads 00.
- R3: Bits that carry no meaning read as 0 whatever was written to them: minutes bit 7, hours bit 6, date bits 7:6, month bits 7:5, day-of-week bits 7:3.
- R4: Fields change only on a tick or a write. On a tick, seconds count 00 to 59 and then wrap to 00, which adds one to the minutes. Minutes wrap from 59 to 00 in the same way and add one to the hours.
- R5: With hours bit 7 clear (24-hour mode), hours bits 5:0 count BCD 00 to 23. Bit 5 is the tens bit for 20 to 23. A wrap from 23 to 00 advances the date.
- R6: With hours bit 7 set (12-hour mode), bits 4:0 count BCD 01 to 12 and bit 5 is the afternoon flag (1 = PM). A step from 11 to 12 toggles the flag. A step from 12 to 01 leaves the flag unchanged. The date advances only on the step from 11 PM to 12 AM.
- R7: On a date advance, months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. After the last day the date becomes 01 and the month advances.
- R8: February ends after day 29 when the year's BCD value is divisible by 4 (00 included), and after day 28 otherwise.
- R9: Each date advance moves the day of week from 7 to 1, and otherwise adds one. Month 12 wraps to 01 and adds one to the year. Year 99 wraps to 00.
- R10: While seconds bit 7 (halt) is 1, ticks leave every byte unchanged. Writes still take effect. After a write that clears the halt bit, ticks count again.
- R11: When a write and a tick fall in the same cycle, the addressed byte takes the written value. Every other byte still follows the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle enable, once per second |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 3 | Byte address for write and read |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Registered read data for `addr` |

## Verification
The range assertions take for granted that every written byte is a legal packed-BCD value for its field. This includes a 12-hour value of 01 to 12 and a date no larger than the length of the month. The counter keeps values legal but does not repair illegal ones. The bench therefore writes only legal values in its sweeps. It sets the meaningless bits only in the masking test, and there it keeps the meaningful bits legal. Ticks are single-cycle pulses with idle cycles between them, the way a divided one-second enable behaves.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned CAL_BYTE_W = 8;
  localparam int unsigned CAL_NREG   = 7;

  typedef enum logic [2:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_DATE  = 3'd3,
    A_MONTH = 3'd4,
    A_DOW   = 3'd5,
    A_YEAR  = 3'd6,
    A_EMPTY = 3'd7
  } cal_addr_e;

  // bits that hold meaning in each byte
  function automatic logic [7:0] cal_mask(input int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'h7F;
      2:       return 8'hBF;
      3:       return 8'h3F;
      4:       return 8'h1F;
      5:       return 8'h07;
      6:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cal_reset(input int unsigned idx);
    case (idx)
      3, 4, 5: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  // add one to a packed two-digit BCD byte
  function automatic logic [7:0] bcd_inc8(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year divisible by 4: (2*tens_lsb + ones) mod 4 == 0
  function automatic logic bcd_leap(input logic [7:0] yr);
    logic [2:0] s;
    s = {1'b0, yr[4], 1'b0} + {1'b0, yr[1:0]};
    return (s[1:0] == 2'd0);
  endfunction

  function automatic logic [7:0] bcd_month_end(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return bcd_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/cal_time_chain.sv
module cal_time_chain
  import cal_pkg::*;
(
  input  logic [7:0] sec_q,
  input  logic [7:0] min_q,
  input  logic [7:0] hour_q,
  output logic [7:0] sec_nx,
  output logic [7:0] min_nx,
  output logic [7:0] hour_nx,
  output logic       day_carry
);
  logic       min_step;
  logic       hour_step;
  logic [7:0] h24;
  logic [7:0] h12;
  logic [7:0] inc24;
  logic [7:0] inc12;

  assign min_step  = (sec_q[6:0] == 7'h59);
  assign hour_step = min_step && (min_q == 8'h59);
  assign h24       = {1'b0, hour_q[6:0]};
  assign h12       = {2'b00, hour_q[6], hour_q[4:0]};
  assign inc24     = bcd_inc8(h24);
  assign inc12     = bcd_inc8(h12);

  always_comb begin
    sec_nx = min_step ? {sec_q[7], 7'h00} : {sec_q[7], bcd_inc8({1'b0, sec_q[6:0]})[6:0]};
    min_nx = min_q;
    if (min_step) min_nx = (min_q == 8'h59) ? 8'h00 : bcd_inc8(min_q);

    hour_nx   = hour_q;
    day_carry = 1'b0;
    if (hour_step) begin
      if (hour_q[7]) begin
        if (h12 == 8'h12) begin
          hour_nx = {2'b10, hour_q[5], 5'h01};
        end else if (h12 == 8'h11) begin
          hour_nx   = {2'b10, ~hour_q[5], 5'h12};
          day_carry = hour_q[5];
        end else begin
          hour_nx = {2'b10, hour_q[5], inc12[4:0]};
        end
      end else begin
        if (h24 == 8'h23) begin
          hour_nx   = 8'h00;
          day_carry = 1'b1;
        end else begin
          hour_nx = {2'b00, inc24[5:0]};
        end
      end
    end
  end
endmodule

// File: rtl/cal_date_chain.sv
module cal_date_chain
  import cal_pkg::*;
(
  input  logic       day_step,
  input  logic [7:0] date_q,
  input  logic [7:0] mon_q,
  input  logic [7:0] dow_q,
  input  logic [7:0] yr_q,
  output logic [7:0] date_nx,
  output logic [7:0] mon_nx,
  output logic [7:0] dow_nx,
  output logic [7:0] yr_nx
);
  logic month_end;
  logic year_end;

  assign month_end = (date_q == bcd_month_end(mon_q, yr_q));
  assign year_end  = month_end && (mon_q == 8'h12);

  always_comb begin
    date_nx = date_q;
    mon_nx  = mon_q;
    dow_nx  = dow_q;
    yr_nx   = yr_q;
    if (day_step) begin
      dow_nx  = (dow_q == 8'h07) ? 8'h01 : bcd_inc8(dow_q);
      date_nx = month_end ? 8'h01 : bcd_inc8(date_q);
      if (month_end) mon_nx = (mon_q == 8'h12) ? 8'h01 : bcd_inc8(mon_q);
      if (year_end)  yr_nx  = (yr_q == 8'h99) ? 8'h00 : bcd_inc8(yr_q);
    end
  end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data
);
  localparam int unsigned NREG = CAL_NREG;

  logic [7:0] cal_q [NREG];
  logic [7:0] cal_d [NREG];
  logic [7:0] sec_q, min_q, hour_q, date_q, mon_q, dow_q, yr_q;
  logic [7:0] sec_nx, min_nx, hour_nx, date_nx, mon_nx, dow_nx, yr_nx;
  logic       day_carry;
  logic       adv;
  logic [7:0] rd_mux;

  assign sec_q  = cal_q[A_SEC];
  assign min_q  = cal_q[A_MIN];
  assign hour_q = cal_q[A_HOUR];
  assign date_q = cal_q[A_DATE];
  assign mon_q  = cal_q[A_MONTH];
  assign dow_q  = cal_q[A_DOW];
  assign yr_q   = cal_q[A_YEAR];

  assign adv = tick_1hz && !sec_q[7];

  cal_time_chain u_time (
    .sec_q    (sec_q),
    .min_q    (min_q),
    .hour_q   (hour_q),
    .sec_nx   (sec_nx),
    .min_nx   (min_nx),
    .hour_nx  (hour_nx),
    .day_carry(day_carry)
  );

  cal_date_chain u_date (
    .day_step(day_carry),
    .date_q  (date_q),
    .mon_q   (mon_q),
    .dow_q   (dow_q),
    .yr_q    (yr_q),
    .date_nx (date_nx),
    .mon_nx  (mon_nx),
    .dow_nx  (dow_nx),
    .yr_nx   (yr_nx)
  );

  always_comb begin
    cal_d[A_SEC]   = sec_nx;
    cal_d[A_MIN]   = min_nx;
    cal_d[A_HOUR]  = hour_nx;
    cal_d[A_DATE]  = date_nx;
    cal_d[A_MONTH] = mon_nx;
    cal_d[A_DOW]   = dow_nx;
    cal_d[A_YEAR]  = yr_nx;
  end

  // one register per byte; a write beats the tick for its own byte
  for (genvar g = 0; g < NREG; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                                   cal_q[g] <= cal_reset(g);
      else if (wr_en && (addr == ADDR_W'(g)))    cal_q[g] <= wr_data & cal_mask(g);
      else if (adv)                              cal_q[g] <= cal_d[g];
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = cal_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else     rd_data <= rd_mux;
  end
endmodule

module bcd_calendar_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_1hz,
  input logic       wr_en,
  input logic [7:0] sec_q,
  input logic [7:0] min_q,
  input logic [7:0] hour_q,
  input logic [7:0] date_q,
  input logic [7:0] mon_q,
  input logic [7:0] dow_q,
  input logic [7:0] yr_q
);
  logic [55:0] all_q;
  assign all_q = {sec_q, min_q, hour_q, date_q, mon_q, dow_q, yr_q};

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick_1hz && !wr_en) |=> $stable(all_q));

  assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (tick_1hz && !wr_en && !sec_q[7] && sec_q[6:0] == 7'h59) |=> (sec_q[6:0] == 7'h00));

  assert_sec_range_R4: assert property (@(posedge clk) disable iff (rst)
    (sec_q[6:0] <= 7'h59) && (sec_q[3:0] <= 4'd9));

  assert_hour24_range_R5: assert property (@(posedge clk) disable iff (rst)
    !hour_q[7] |-> ((hour_q[5:0] <= 6'h23) && (hour_q[3:0] <= 4'd9)));

  assert_hour12_range_R6: assert property (@(posedge clk) disable iff (rst)
    hour_q[7] |-> ((hour_q[4:0] >= 5'h01) && (hour_q[4:0] <= 5'h12) && (hour_q[3:0] <= 4'd9)));

  assert_zero_bits_R3: assert property (@(posedge clk) disable iff (rst)
    (min_q[7] == 1'b0) && (hour_q[6] == 1'b0) && (date_q[7:6] == 2'b00) &&
    (mon_q[7:5] == 3'b000) && (dow_q[7:3] == 5'b00000));

  assert_month_range_R7: assert property (@(posedge clk) disable iff (rst)
    (mon_q >= 8'h01) && (mon_q <= 8'h12));

  assert_dow_range_R9: assert property (@(posedge clk) disable iff (rst)
    (dow_q >= 8'h01) && (dow_q <= 8'h07));

  assert_halt_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (sec_q[7] && !wr_en) |=> $stable(all_q));
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_1hz(tick_1hz),
  .wr_en   (wr_en),
  .sec_q   (sec_q),
  .min_q   (min_q),
  .hour_q  (hour_q),
  .date_q  (date_q),
  .mon_q   (mon_q),
  .dow_q   (dow_q),
  .yr_q    (yr_q)
);

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  bcd_calendar u_bcd_calendar (
    .clk     (clk),
    .rst     (rst),
    .tick_1hz(tick_1hz),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_run  = n_run + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  function automatic logic [7:0] bcd(input int n);
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run = n_run + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic tick_once();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                         input logic [7:0] dt, input logic [7:0] mo, input logic [7:0] dw,
                         input logic [7:0] yr);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dt);
    wr(3'd4, mo); wr(3'd5, dw); wr(3'd6, yr);
  endtask

  logic [7:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values, R2 empty address
    rd(3'd0, v); check("R1 sec", v, 8'h00);
    rd(3'd1, v); check("R1 min", v, 8'h00);
    rd(3'd2, v); check("R1 hour", v, 8'h00);
    rd(3'd3, v); check("R1 date", v, 8'h01);
    rd(3'd4, v); check("R1 month", v, 8'h01);
    rd(3'd5, v); check("R1 dow", v, 8'h01);
    rd(3'd6, v); check("R1 year", v, 8'h00);
    rd(3'd7, v); check("R2 empty", v, 8'h00);

    // R2 write and read back each byte
    set_all(8'h09, 8'h17, 8'h42, 8'h25, 8'h11, 8'h06, 8'h73);
    wr(3'd7, 8'hAA);
    rd(3'd0, v); check("R2 sec", v, 8'h42);
    rd(3'd1, v); check("R2 min", v, 8'h17);
    rd(3'd2, v); check("R2 hour", v, 8'h09);
    rd(3'd3, v); check("R2 date", v, 8'h25);
    rd(3'd4, v); check("R2 month", v, 8'h11);
    rd(3'd5, v); check("R2 dow", v, 8'h06);
    rd(3'd6, v); check("R2 year", v, 8'h73);
    rd(3'd7, v); check("R2 empty write", v, 8'h00);

    // R3 meaningless bits
    wr(3'd1, 8'h85); rd(3'd1, v); check("R3 min", v, 8'h05);
    wr(3'd2, 8'h52); rd(3'd2, v); check("R3 hour", v, 8'h12);
    wr(3'd3, 8'hD5); rd(3'd3, v); check("R3 date", v, 8'h15);
    wr(3'd4, 8'hE5); rd(3'd4, v); check("R3 month", v, 8'h05);
    wr(3'd5, 8'hFD); rd(3'd5, v); check("R3 dow", v, 8'h05);

    // R4 seconds sweep and minutes sweep
    for (int s = 0; s < 60; s++) begin
      set_all(8'h05, 8'h30, bcd(s), 8'h10, 8'h05, 8'h03, 8'h21);
      tick_once();
      rd(3'd0, v); check("R4 sec", v, bcd((s + 1) % 60));
      rd(3'd1, v); check("R4 min carry", v, (s == 59) ? 8'h31 : 8'h30);
    end
    for (int m = 0; m < 60; m++) begin
      set_all(8'h05, bcd(m), 8'h59, 8'h10, 8'h05, 8'h03, 8'h21);
      tick_once();
      rd(3'd1, v); check("R4 min", v, bcd((m + 1) % 60));
      rd(3'd2, v); check("R4 hour carry", v, (m == 59) ? 8'h06 : 8'h05);
    end

    // R5 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      set_all(bcd(h), 8'h59, 8'h59, 8'h10, 8'h05, 8'h03, 8'h21);
      tick_once();
      rd(3'd2, v); check("R5 hour", v, bcd((h + 1) % 24));
      rd(3'd3, v); check("R5 date", v, (h == 23) ? 8'h11 : 8'h10);
    end

    // R6 12-hour sweep, both halves of the day
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        logic [7:0] eh;
        int nh;
        int npm;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        eh  = 8'h80 | (npm != 0 ? 8'h20 : 8'h00) | bcd(nh);
        set_all(8'h80 | (pm != 0 ? 8'h20 : 8'h00) | bcd(h), 8'h59, 8'h59,
                8'h10, 8'h05, 8'h03, 8'h21);
        tick_once();
        rd(3'd2, v); check("R6 hour", v, eh);
        rd(3'd3, v); check("R6 date", v, (h == 11 && pm == 1) ? 8'h11 : 8'h10);
      end
    end

    // R7 month lengths: last day minus one, then last day
    for (int m = 1; m <= 12; m++) begin
      int ml;
      ml = mlen(m, 21);
      set_all(8'h23, 8'h59, 8'h59, bcd(ml - 1), bcd(m), 8'h02, 8'h21);
      tick_once();
      rd(3'd3, v); check("R7 date mid", v, bcd(ml));
      rd(3'd4, v); check("R7 month hold", v, bcd(m));
      set_all(8'h23, 8'h59, 8'h59, bcd(ml), bcd(m), 8'h02, 8'h21);
      tick_once();
      rd(3'd3, v); check("R7 date wrap", v, 8'h01);
      rd(3'd4, v); check("R7 month next", v, bcd(m % 12 + 1));
    end

    // R8 February across every year
    for (int y = 0; y < 100; y++) begin
      set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, 8'h04, bcd(y));
      tick_once();
      rd(3'd3, v); check("R8 feb date", v, (y % 4 == 0) ? 8'h29 : 8'h01);
      rd(3'd4, v); check("R8 feb month", v, (y % 4 == 0) ? 8'h02 : 8'h03);
    end

    // R9 day of week wrap, year wrap and year step
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h07, 8'h99);
    tick_once();
    rd(3'd5, v); check("R9 dow wrap", v, 8'h01);
    rd(3'd4, v); check("R9 month wrap", v, 8'h01);
    rd(3'd6, v); check("R9 year wrap", v, 8'h00);
    rd(3'd0, v); check("R9 sec", v, 8'h00);
    set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h04, 8'h19);
    tick_once();
    rd(3'd6, v); check("R9 year step", v, 8'h20);
    rd(3'd5, v); check("R9 dow step", v, 8'h05);

    // R10 halt freezes, writes still land, clearing restarts
    set_all(8'h10, 8'h20, 8'h85, 8'h10, 8'h05, 8'h03, 8'h21);
    repeat (5) tick_once();
    rd(3'd0, v); check("R10 halted sec", v, 8'h85);
    rd(3'd1, v); check("R10 halted min", v, 8'h20);
    wr(3'd1, 8'h44);
    rd(3'd1, v); check("R10 write while halted", v, 8'h44);
    wr(3'd0, 8'h30);
    tick_once();
    rd(3'd0, v); check("R10 restart", v, 8'h31);

    // R11 write and tick in the same cycle
    set_all(8'h10, 8'h20, 8'h59, 8'h10, 8'h05, 8'h03, 8'h21);
    tick_1hz = 1'b1;
    wr(3'd1, 8'h10);
    tick_1hz = 1'b0;
    @(negedge clk);
    rd(3'd1, v); check("R11 written min", v, 8'h10);
    rd(3'd0, v); check("R11 sec follows tick", v, 8'h00);
    set_all(8'h10, 8'h20, 8'h40, 8'h10, 8'h05, 8'h03, 8'h21);
    tick_1hz = 1'b1;
    wr(3'd0, 8'h20);
    tick_1hz = 1'b0;
    @(negedge clk);
    rd(3'd0, v); check("R11 written sec", v, 8'h20);
    rd(3'd1, v); check("R11 min unchanged", v, 8'h20);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule